// File: doc/BRIEF.md
# Hardware Thread Run/Park Controller

This block sits beside the thread pipelines of one core and decides which hardware threads may issue instructions. Software sees a small register window on a simple bus: a read-only mask of the threads that exist on the core, one running mask, and a read-only status mask. The running mask can be reached at three addresses. One loads it directly. One sets the bits written as 1. One clears the bits written as 1. Clearing a thread's running bit parks it, and setting the bit again lets it resume.

Each thread gets a park request from this block and returns an idle acknowledge once its pipeline has drained. The status mask follows the threads' real state, not the requested state. A bit drops only once the thread has actually stopped, and it comes back one cycle after the thread is released. Writes are always limited to enabled threads. The block refuses any write that would leave no thread running.

Top module: `thread_park_ctrl`

## Requirements
- R1: Address 0 returns the enabled mask captured from `enableCfg` while `rstN` is low. A captured all-zero value is treated as thread 0 only. Writes to address 0 have no effect.
- R2: On reset the running mask holds only the lowest-numbered enabled thread, and the status mask holds the same value.
- R3: A write to address 1 loads the running mask with (write data AND enabled mask). Reading address 1 returns the running mask.
- R4: A write to address 2 ORs the write data into the running mask, limited to enabled threads.
- R5: A write to address 3 clears every running bit whose write-data bit is 1.
- R6: Reads of addresses 2 and 3 return the running mask.
- R7: Any write that would make the running mask all zeros is dropped, and the running mask keeps its old value.
- R8: `threadPark[n]` is the inverse of running bit n, and bit n always means thread n. It changes at the clock edge that accepts the write.
- R9: A status bit becomes 1 on the clock edge after the edge at which its running bit is 1.
- R10: A status bit becomes 0 only on an edge where its running bit is 0 and `threadIdle` for that thread is 1. Until then it holds 1.
- R11: Address 4 returns the status mask and ignores writes. Addresses 5 to 7 read as 0, and writes to them have no effect.
- R12: Read bits at positions of non-enabled threads, and all bits from `NUM_THREADS` upward, are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also the capture window for `enableCfg` |
| enableCfg | input | NUM_THREADS | Static mask of the threads that exist and are enabled |
| busAddr | input | ADDR_W | Register address (word index) |
| busWe | input | 1 | Write strobe, acted on at the rising clock edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| threadPark | output | NUM_THREADS | Park request per thread |
| threadIdle | input | NUM_THREADS | Per-thread acknowledge that the pipeline is drained |

## Verification
A running mask that is set wrongly shows up right away. The park outputs and the alias reads expose it in the same cycle as the faulty edge. A bad status bit is slower to see: it only shows one edge later, and a missing idle qualification can hide until a thread's acknowledge is held low on purpose. For that reason the directed sequence stalls two threads' acknowledges and reads the status before and after they are released. The vector table walks each alias through accepted, masked and refused writes. Each step is read back through a different address, so a wrong decode shows as a wrong value at once.

// File: rtl/tpark_pkg.sv
package tpark_pkg;
  localparam int ADR_ENABLED = 0;
  localparam int ADR_RUN_RW  = 1;
  localparam int ADR_RUN_SET = 2;
  localparam int ADR_RUN_CLR = 3;
  localparam int ADR_STATUS  = 4;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_EN,
    SEL_RUN,
    SEL_STAT
  } rdSel_e;

  // write strobes from control to datapath; at most one is active
  typedef struct packed {
    logic ldRaw;
    logic setBits;
    logic clrBits;
  } runStrobe_t;
endpackage

// File: rtl/tpark_ctrl.sv
module tpark_ctrl
  import tpark_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output runStrobe_t        strobe,
  output rdSel_e            rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = SEL_ZERO;
    case (int'(busAddr))
      ADR_ENABLED: rdSel = SEL_EN;
      ADR_RUN_RW: begin
        rdSel        = SEL_RUN;
        strobe.ldRaw = busWe;
      end
      ADR_RUN_SET: begin
        rdSel          = SEL_RUN;
        strobe.setBits = busWe;
      end
      ADR_RUN_CLR: begin
        rdSel          = SEL_RUN;
        strobe.clrBits = busWe;
      end
      ADR_STATUS: rdSel = SEL_STAT;
      default:    rdSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/tpark_stat_cell.sv
module tpark_stat_cell (
  input  logic clk,
  input  logic rstN,
  input  logic initVal,
  input  logic runBit,
  input  logic idleAck,
  output logic statBit
);
  always_ff @(posedge clk) begin
    if (!rstN)        statBit <= initVal;
    else if (runBit)  statBit <= 1'b1;
    else if (idleAck) statBit <= 1'b0;
  end

  p_rise_after_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && runBit) |=> statBit);

  p_fall_needs_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(statBit)) |-> $past(!runBit && idleAck));
endmodule

// File: rtl/tpark_datapath.sv
module tpark_datapath
  import tpark_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int DATA_W      = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] enableCfg,
  input  runStrobe_t             strobe,
  input  rdSel_e                 rdSel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NUM_THREADS-1:0] threadIdle,
  output logic [DATA_W-1:0]      rdata,
  output logic [NUM_THREADS-1:0] threadPark
);
  localparam int NT = NUM_THREADS;

  logic [NT-1:0] enMask, runMask, statMask;
  logic [NT-1:0] cfgEff, lowestEn, wdLow, candMask;
  logic          applyWr;

  assign cfgEff   = (|enableCfg) ? enableCfg : NT'(1);
  assign lowestEn = cfgEff & (~cfgEff + NT'(1));
  assign wdLow    = wdata[NT-1:0];

  always_comb begin
    candMask = runMask;
    if (strobe.ldRaw)        candMask = wdLow & enMask;
    else if (strobe.setBits) candMask = (runMask | wdLow) & enMask;
    else if (strobe.clrBits) candMask = runMask & ~wdLow;
  end

  assign applyWr = (|strobe) && (|candMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= cfgEff;
      runMask <= lowestEn;
    end else if (applyWr) begin
      runMask <= candMask;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_stat
    tpark_stat_cell u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .initVal (lowestEn[t]),
      .runBit  (runMask[t]),
      .idleAck (threadIdle[t]),
      .statBit (statMask[t])
    );
  end

  assign threadPark = ~runMask;

  always_comb begin
    rdata = '0;
    case (rdSel)
      SEL_EN:   rdata[NT-1:0] = enMask;
      SEL_RUN:  rdata[NT-1:0] = runMask;
      SEL_STAT: rdata[NT-1:0] = statMask;
      default:  rdata = '0;
    endcase
  end

  p_en_static_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(enMask));

  p_run_never_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (runMask != '0));

  p_dropped_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (|strobe) && (candMask == '0)) |=> $stable(runMask));

  p_run_within_en_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((runMask & ~enMask) == '0));

  p_stat_within_en_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(rstN)) |-> ((statMask & ~enMask) == '0));
endmodule

// File: rtl/thread_park_ctrl.sv
module thread_park_ctrl
  import tpark_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] enableCfg,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWe,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_THREADS-1:0] threadPark,
  input  logic [NUM_THREADS-1:0] threadIdle
);
  runStrobe_t strobe;
  rdSel_e     rdSel;

  tpark_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  tpark_datapath #(.NUM_THREADS(NUM_THREADS), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enableCfg  (enableCfg),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .wdata      (busWdata),
    .threadIdle (threadIdle),
    .rdata      (busRdata),
    .threadPark (threadPark)
  );
endmodule

// File: tb/thread_park_ctrl_bench.sv
module thread_park_ctrl_bench;
  localparam int NT = 8;
  localparam int DW = 64;
  localparam int AW = 3;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] enableCfg = 8'hB6;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NT-1:0] threadPark;
  logic [NT-1:0] threadIdle = '1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  thread_park_ctrl #(.NUM_THREADS(NT), .DATA_W(DW), .ADDR_W(AW)) u_thread_park_ctrl (
    .clk(clk), .rstN(rstN), .enableCfg(enableCfg), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .threadPark(threadPark), .threadIdle(threadIdle)
  );

  // entry: {req[26:23], we[22], addr[21:19], wd[18:11], rdAddr[10:8], exp[7:0]}
  // enabled = B6, so the lowest enabled thread is 1
  localparam logic [26:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd0, 8'h00, 3'd0, 8'hB6},  // R1 enabled mask
    {4'd2,  1'b0, 3'd0, 8'h00, 3'd1, 8'h02},  // R2 reset running
    {4'd4,  1'b1, 3'd2, 8'hFF, 3'd1, 8'hB6},  // R4 set all, masked
    {4'd9,  1'b0, 3'd0, 8'h00, 3'd4, 8'hB6},  // R9 status follows
    {4'd5,  1'b1, 3'd3, 8'hFD, 3'd1, 8'h02},  // R5 clear all but thread 1
    {4'd10, 1'b0, 3'd0, 8'h00, 3'd4, 8'h02},  // R10 drained threads drop
    {4'd6,  1'b0, 3'd0, 8'h00, 3'd2, 8'h02},  // R6 set alias reads run
    {4'd7,  1'b1, 3'd3, 8'h02, 3'd1, 8'h02},  // R7 clear of last thread dropped
    {4'd3,  1'b1, 3'd1, 8'hFF, 3'd3, 8'hB6},  // R3 raw load, read via clr alias
    {4'd7,  1'b1, 3'd1, 8'h49, 3'd1, 8'hB6},  // R7 raw load of only disabled bits dropped
    {4'd3,  1'b1, 3'd1, 8'h30, 3'd1, 8'h30},  // R3 raw load subset
    {4'd1,  1'b1, 3'd0, 8'h00, 3'd0, 8'hB6},  // R1 write to enabled ignored
    {4'd11, 1'b1, 3'd4, 8'hFF, 3'd1, 8'h30},  // R11 write to status no effect
    {4'd11, 1'b1, 3'd5, 8'hFF, 3'd5, 8'h00},  // R11 unmapped reads zero
    {4'd11, 1'b1, 3'd4, 8'h00, 3'd4, 8'h30},  // R11 status unchanged by write
    {4'd4,  1'b1, 3'd2, 8'h49, 3'd1, 8'h30},  // R4 set of disabled bits only
    {4'd4,  1'b1, 3'd2, 8'h80, 3'd4, 8'hB0}   // R4 set thread 7, status follows
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic doReset(input logic [NT-1:0] cfg);
    @(negedge clk);
    rstN = 1'b0;
    enableCfg = cfg;
    busWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    doReset(8'hB6);
    @(negedge clk);
    // R2 / R8 reset state at ports
    check("R8", {56'd0, threadPark}, 64'hFD);
    readChk("R2", 3'd4, 64'h02);

    for (int i = 0; i < NV; i++) begin
      busAddr  = VEC[i][21:19];
      busWe    = VEC[i][22];
      busWdata = {56'd0, VEC[i][18:11]};
      @(negedge clk);
      busWe = 1'b0;
      @(negedge clk);
      busAddr = VEC[i][10:8];
      #1;
      check($sformatf("R%0d vector %0d", VEC[i][26:23], i), busRdata, {56'd0, VEC[i][7:0]});
    end

    // running = B0; stall acknowledges of threads 4 and 5 (R10)
    threadIdle = 8'hCF;
    busAddr = 3'd3; busWe = 1'b1; busWdata = 64'h30;
    @(negedge clk);
    busWe = 1'b0;
    readChk("R5", 3'd1, 64'h80);
    check("R8", {56'd0, threadPark}, 64'h7F);
    readChk("R10", 3'd4, 64'hB0);
    @(negedge clk);
    readChk("R10", 3'd4, 64'hB0);
    threadIdle = 8'hDF;
    @(negedge clk);
    readChk("R10", 3'd4, 64'hA0);
    busAddr = 3'd2; busWe = 1'b1; busWdata = 64'h10;
    @(negedge clk);
    busWe = 1'b0;
    readChk("R4", 3'd1, 64'h90);
    readChk("R9", 3'd4, 64'hA0);
    @(negedge clk);
    readChk("R9", 3'd4, 64'hB0);
    threadIdle = '1;

    // upper data bits are ignored (R12, R7)
    busAddr = 3'd1; busWe = 1'b1; busWdata = 64'hFFFF_FFFF_FFFF_FF00;
    @(negedge clk);
    busWe = 1'b0;
    readChk("R7", 3'd1, 64'h90);
    busAddr = 3'd1; busWe = 1'b1; busWdata = '1;
    @(negedge clk);
    busWe = 1'b0;
    readChk("R12", 3'd1, 64'hB6);
    @(negedge clk);
    readChk("R12", 3'd4, 64'hB6);

    // all-zero configuration falls back to thread 0 (R1, R2)
    doReset(8'h00);
    @(negedge clk);
    readChk("R1", 3'd0, 64'h01);
    readChk("R2", 3'd1, 64'h01);
    readChk("R2", 3'd4, 64'h01);

    finishRun();
  end
endmodule